// File: doc/BRIEF.md
# Memory Test-Agent Run Sequencer

This block runs one pass of a built-in memory test agent from start to finish. On a start pulse it takes two setup words (pattern base and address offset), a two-bit pattern-mode code, an operation select and a log2 loop count. It first clears every agent enable. It then programs the agent's pattern controls and opens the write phase, the read phase, or the write phase followed by the read phase.

After the last compare-complete status the block waits a fixed guard interval. It then samples the agent's compare-error word, drops the read enable and returns the word with a one-cycle valid pulse. A zero word means the memory passed. A fault flag marks runs that never started because of bad parameters, and runs that were aborted because compare-complete never came.

The pattern generator and the memory itself sit outside the block. The agent's enables and pattern controls are outputs, and its compare-complete and error word are inputs.

Top module: `memtest_run_ctrl`

## Requirements
- R1: After reset both agent enables, the result valid, the fault flag, busy, the audio and crosstalk selects, the inversion bit, the write-after-read bit and the seed and step values are all zero.
- R2: A start with a loop count above 15 gives a result pulse one cycle later with fault set and error word zero. No agent enable is ever raised for that start.
- R3: The mode code is {crosstalk, audio}, where 00 is ISI, 01 is audio and 10 is crosstalk. Code 11 is rejected in the same way as R2. Audio and crosstalk are never both selected.
- R4: Audio mode sets the audio select and clears crosstalk. It also loads seed 0x11, step 0x0D and inversion 1, and sets write-after-read, which stays set for a write-then-read run.
- R5: Crosstalk mode sets the crosstalk select and clears audio, inversion and write-after-read.
- R6: ISI mode clears both selects. The seed, step, inversion and write-after-read values stay as the previous run left them, even for a read-check run.
- R7: A read-check run in audio or crosstalk mode has write-after-read cleared by the time read is enabled. For read-check (opWrite=0), read is the only enable raised.
- R8: A write-then-read run (opWrite=1) raises write alone first. On compare-complete it drops write, holds both enables low for exactly one cycle, and then raises read. Write and read are never high together.
- R9: The result valid rises exactly GUARD_CYCLES+1 cycles after compare-complete rises in the read phase. The error word is the compare-error input of that cycle, and read is low in the same cycle.
- R10: The result valid lasts exactly one cycle and comes once per accepted or rejected start. A completed run reports fault 0 and the sampled word, where 0 means pass.
- R11: If compare-complete stays low for TIMEOUT_CYCLES cycles of a wait phase, both enables drop and the result pulses with fault 1 and error word 0. In the read phase this happens exactly TIMEOUT_CYCLES cycles after read rises.
- R12: A start pulse while busy is ignored. It neither alters the run in progress nor queues a second run.
- R13: Throughout a run the agent sees the loop count and the two setup words captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request |
| setupA | input | DATA_W | Pattern base word |
| setupB | input | DATA_W | Address offset word |
| modeSel | input | 2 | {crosstalk, audio} pattern code |
| opWrite | input | 1 | 1: write then read-check, 0: read-check only |
| loopLog2 | input | LOOP_W+1 | Log2 loop count, legal 0..15 |
| cmpDone | input | 1 | Agent compare-complete status |
| cmpErr | input | DATA_W | Agent compare-error word |
| agentWrEn | output | 1 | Agent write enable |
| agentRdEn | output | 1 | Agent read enable |
| agentAudio | output | 1 | Audio pattern select |
| agentXtalk | output | 1 | Crosstalk pattern select |
| agentInvert | output | 1 | Audio bit inversion |
| agentWarMode | output | 1 | Write-after-read mode |
| agentSeed | output | SEED_W | Audio initial value |
| agentStep | output | SEED_W | Audio increment |
| agentLoop | output | LOOP_W | Loop count presented to agent |
| agentSetupA | output | DATA_W | Captured pattern base |
| agentSetupB | output | DATA_W | Captured offset |
| busy | output | 1 | Run in progress |
| resValid | output | 1 | One-cycle result strobe |
| resFault | output | 1 | Rejected or timed-out run |
| resErrWord | output | DATA_W | Compare-error result, 0 = pass |

## Verification
If the sequencer holds a wrong state, the agent enables show it at once. An early read enable, a missing idle cycle between write and read, or a stuck write is visible on agentWrEn/agentRdEn within one cycle of the compare-complete that should have moved it. A guard counter that is off by even one cycle moves the result strobe relative to compare-complete. It can also capture the placeholder word the agent model drives before completion, so the fault shows on the first run that reaches the read phase. Mode registers that fail to hold or clear show up on the pattern controls at the next read enable, which is why ISI runs are placed after audio and crosstalk runs.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  // Audio pattern constants (values the agent expects)
  localparam int AUD_SEED = 17;   // 0x11
  localparam int AUD_STEP = 13;   // 0x0D

  // Mode code: bit1 = crosstalk, bit0 = audio
  localparam logic [1:0] MODE_ISI   = 2'b00;
  localparam logic [1:0] MODE_AUDIO = 2'b01;
  localparam logic [1:0] MODE_XTALK = 2'b10;
  localparam logic [1:0] MODE_BAD   = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROGRAM,
    ST_LAUNCH,
    ST_WR_WAIT,
    ST_WR_OFF,
    ST_RD_WAIT,
    ST_GUARD
  } runState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAll;     // drop both enables
    logic latchCfg;   // capture setup words, loop, mode
    logic applyMode;  // program pattern controls
    logic wrSet;
    logic wrClr;
    logic rdSet;
    logic readOnly;   // clear write-after-read
    logic capture;    // sample error word, drop read, report
    logic fault;      // report fault, drop enables
  } runStrobe_t;

endpackage

// File: rtl/memtest_ctrl.sv
module memtest_ctrl
  import memtest_pkg::*;
#(
  parameter int LOOP_W         = 4,
  parameter int GUARD_CYCLES   = 4,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        modeSel,
  input  logic              opWrite,
  input  logic [LOOP_W:0]   loopLog2,
  input  logic              cmpDone,
  output logic              busy,
  output runStrobe_t        stb
);

  localparam int GCNT_W = (GUARD_CYCLES > 1) ? $clog2(GUARD_CYCLES) : 1;
  localparam int TCNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [LOOP_W:0]   LOOP_MAX  = (LOOP_W+1)'((1 << LOOP_W) - 1);
  localparam logic [GCNT_W-1:0] GUARD_END = GCNT_W'(GUARD_CYCLES - 1);
  localparam logic [TCNT_W-1:0] TMO_END   = TCNT_W'(TIMEOUT_CYCLES - 1);

  runState_t        state, stateNext;
  logic [GCNT_W-1:0] guardCnt;
  logic [TCNT_W-1:0] tmoCnt;
  logic             opWrQ;
  logic             roNeedQ;

  logic startBad;
  logic tmoHit;
  logic inWait;

  assign startBad = (loopLog2 > LOOP_MAX) || (modeSel == MODE_BAD);
  assign inWait   = (state == ST_WR_WAIT) || (state == ST_RD_WAIT);
  assign tmoHit   = inWait && !cmpDone && (tmoCnt == TMO_END);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (startBad) begin
            stb.fault = 1'b1;
          end else begin
            stb.clrAll   = 1'b1;
            stb.latchCfg = 1'b1;
            stateNext    = ST_PROGRAM;
          end
        end
      end
      ST_PROGRAM: begin
        stb.applyMode = 1'b1;
        stateNext     = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        if (opWrQ) begin
          stb.wrSet = 1'b1;
          stateNext = ST_WR_WAIT;
        end else begin
          stb.rdSet    = 1'b1;
          stb.readOnly = roNeedQ;
          stateNext    = ST_RD_WAIT;
        end
      end
      ST_WR_WAIT: begin
        if (cmpDone) begin
          stb.wrClr = 1'b1;
          stateNext = ST_WR_OFF;
        end else if (tmoHit) begin
          stb.fault = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_WR_OFF: begin
        stb.rdSet = 1'b1;
        stateNext = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (cmpDone) begin
          stateNext = ST_GUARD;
        end else if (tmoHit) begin
          stb.fault = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_GUARD: begin
        if (guardCnt == GUARD_END) begin
          stb.capture = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      guardCnt <= '0;
      tmoCnt   <= '0;
      opWrQ    <= 1'b0;
      roNeedQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start && !startBad) begin
        opWrQ   <= opWrite;
        roNeedQ <= !opWrite && (modeSel != MODE_ISI);
      end
      // timeout counter restarts whenever a wait phase is entered
      if (inWait && stateNext == state) tmoCnt <= tmoCnt + 1'b1;
      else                              tmoCnt <= '0;
      if (state == ST_GUARD) guardCnt <= guardCnt + 1'b1;
      else                   guardCnt <= '0;
    end
  end

endmodule

// File: rtl/memtest_dp.sv
module memtest_dp
  import memtest_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LOOP_W = 4,
  parameter int SEED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  runStrobe_t        stb,
  input  logic [DATA_W-1:0] setupA,
  input  logic [DATA_W-1:0] setupB,
  input  logic [1:0]        modeSel,
  input  logic [LOOP_W-1:0] loopIn,
  input  logic [DATA_W-1:0] cmpErr,
  output logic              agentWrEn,
  output logic              agentRdEn,
  output logic              agentAudio,
  output logic              agentXtalk,
  output logic              agentInvert,
  output logic              agentWarMode,
  output logic [SEED_W-1:0] agentSeed,
  output logic [SEED_W-1:0] agentStep,
  output logic [LOOP_W-1:0] agentLoop,
  output logic [DATA_W-1:0] agentSetupA,
  output logic [DATA_W-1:0] agentSetupB,
  output logic              resValid,
  output logic              resFault,
  output logic [DATA_W-1:0] resErrWord
);

  localparam logic [SEED_W-1:0] SEED_VAL = SEED_W'(AUD_SEED);
  localparam logic [SEED_W-1:0] STEP_VAL = SEED_W'(AUD_STEP);

  logic [1:0] modeQ;

  // Enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agentWrEn <= 1'b0;
      agentRdEn <= 1'b0;
    end else begin
      if (stb.clrAll || stb.fault || stb.wrClr) agentWrEn <= 1'b0;
      else if (stb.wrSet)                       agentWrEn <= 1'b1;
      if (stb.clrAll || stb.fault || stb.capture) agentRdEn <= 1'b0;
      else if (stb.rdSet)                         agentRdEn <= 1'b1;
    end
  end

  // Captured configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ       <= MODE_ISI;
      agentLoop   <= '0;
      agentSetupA <= '0;
      agentSetupB <= '0;
    end else if (stb.latchCfg) begin
      modeQ       <= modeSel;
      agentLoop   <= loopIn;
      agentSetupA <= setupA;
      agentSetupB <= setupB;
    end
  end

  // Pattern controls: ISI leaves the audio-specific settings untouched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agentAudio   <= 1'b0;
      agentXtalk   <= 1'b0;
      agentInvert  <= 1'b0;
      agentWarMode <= 1'b0;
      agentSeed    <= '0;
      agentStep    <= '0;
    end else begin
      if (stb.applyMode) begin
        unique case (modeQ)
          MODE_AUDIO: begin
            agentAudio   <= 1'b1;
            agentXtalk   <= 1'b0;
            agentInvert  <= 1'b1;
            agentWarMode <= 1'b1;
            agentSeed    <= SEED_VAL;
            agentStep    <= STEP_VAL;
          end
          MODE_XTALK: begin
            agentAudio   <= 1'b0;
            agentXtalk   <= 1'b1;
            agentInvert  <= 1'b0;
            agentWarMode <= 1'b0;
          end
          default: begin
            agentAudio <= 1'b0;
            agentXtalk <= 1'b0;
          end
        endcase
      end else if (stb.readOnly) begin
        agentWarMode <= 1'b0;
      end
    end
  end

  // Result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid   <= 1'b0;
      resFault   <= 1'b0;
      resErrWord <= '0;
    end else begin
      resValid <= stb.capture || stb.fault;
      if (stb.capture) begin
        resFault   <= 1'b0;
        resErrWord <= cmpErr;
      end else if (stb.fault) begin
        resFault   <= 1'b1;
        resErrWord <= '0;
      end
    end
  end

endmodule

// File: rtl/memtest_run_ctrl.sv
module memtest_run_ctrl
  import memtest_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int LOOP_W         = 4,
  parameter int SEED_W         = 8,
  parameter int GUARD_CYCLES   = 4,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] setupA,
  input  logic [DATA_W-1:0] setupB,
  input  logic [1:0]        modeSel,
  input  logic              opWrite,
  input  logic [LOOP_W:0]   loopLog2,
  input  logic              cmpDone,
  input  logic [DATA_W-1:0] cmpErr,
  output logic              agentWrEn,
  output logic              agentRdEn,
  output logic              agentAudio,
  output logic              agentXtalk,
  output logic              agentInvert,
  output logic              agentWarMode,
  output logic [SEED_W-1:0] agentSeed,
  output logic [SEED_W-1:0] agentStep,
  output logic [LOOP_W-1:0] agentLoop,
  output logic [DATA_W-1:0] agentSetupA,
  output logic [DATA_W-1:0] agentSetupB,
  output logic              busy,
  output logic              resValid,
  output logic              resFault,
  output logic [DATA_W-1:0] resErrWord
);

  runStrobe_t stb;

  memtest_ctrl #(
    .LOOP_W(LOOP_W), .GUARD_CYCLES(GUARD_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .modeSel(modeSel),
    .opWrite(opWrite), .loopLog2(loopLog2), .cmpDone(cmpDone),
    .busy(busy), .stb(stb)
  );

  memtest_dp #(
    .DATA_W(DATA_W), .LOOP_W(LOOP_W), .SEED_W(SEED_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .setupA(setupA), .setupB(setupB), .modeSel(modeSel),
    .loopIn(loopLog2[LOOP_W-1:0]), .cmpErr(cmpErr),
    .agentWrEn(agentWrEn), .agentRdEn(agentRdEn),
    .agentAudio(agentAudio), .agentXtalk(agentXtalk),
    .agentInvert(agentInvert), .agentWarMode(agentWarMode),
    .agentSeed(agentSeed), .agentStep(agentStep), .agentLoop(agentLoop),
    .agentSetupA(agentSetupA), .agentSetupB(agentSetupB),
    .resValid(resValid), .resFault(resFault), .resErrWord(resErrWord)
  );

endmodule

// File: rtl/memtest_run_ctrl_chk.sv
module memtest_run_ctrl_chk #(
  parameter int SEED_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              agentWrEn,
  input logic              agentRdEn,
  input logic              agentAudio,
  input logic              agentXtalk,
  input logic [SEED_W-1:0] agentSeed,
  input logic [SEED_W-1:0] agentStep,
  input logic              busy,
  input logic              resValid,
  input logic              resFault
);

  AST_NO_DUAL_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(agentWrEn && agentRdEn)); // R8

  AST_GAP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(agentWrEn) |-> !agentRdEn); // R8

  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |=> !resValid); // R10

  AST_READ_OFF_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> !agentRdEn); // R9

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resFault) |-> (!agentWrEn && !agentRdEn)); // R11

  AST_SELECTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(agentAudio && agentXtalk)); // R3

  AST_AUDIO_CONSTANTS: assert property (@(posedge clk) disable iff (!rst_n)
    agentAudio |-> (agentSeed == SEED_W'(17) && agentStep == SEED_W'(13))); // R4

  AST_ENABLE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (agentWrEn || agentRdEn) |-> busy); // R12

endmodule

bind memtest_run_ctrl memtest_run_ctrl_chk #(.SEED_W(SEED_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .agentWrEn(agentWrEn), .agentRdEn(agentRdEn),
  .agentAudio(agentAudio), .agentXtalk(agentXtalk),
  .agentSeed(agentSeed), .agentStep(agentStep),
  .busy(busy), .resValid(resValid), .resFault(resFault)
);

// File: tb/memtest_run_ctrl_tb_top.sv
module memtest_run_ctrl_tb_top;

  localparam int GUARD = 3;
  localparam int TMO   = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] setupA = '0, setupB = '0;
  logic [1:0]  modeSel = '0;
  logic        opWrite = 1'b0;
  logic [4:0]  loopLog2 = '0;
  logic        cmpDone;
  logic [31:0] cmpErr;
  logic        agentWrEn, agentRdEn, agentAudio, agentXtalk, agentInvert, agentWarMode;
  logic [7:0]  agentSeed, agentStep;
  logic [3:0]  agentLoop;
  logic [31:0] agentSetupA, agentSetupB;
  logic        busy, resValid, resFault;
  logic [31:0] resErrWord;

  int nChk = 0;
  int nFail = 0;
  int cycles = 0;

  always #4 clk = ~clk;   // 125 MHz

  memtest_run_ctrl #(.GUARD_CYCLES(GUARD), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .setupA(setupA), .setupB(setupB),
    .modeSel(modeSel), .opWrite(opWrite), .loopLog2(loopLog2),
    .cmpDone(cmpDone), .cmpErr(cmpErr),
    .agentWrEn(agentWrEn), .agentRdEn(agentRdEn), .agentAudio(agentAudio),
    .agentXtalk(agentXtalk), .agentInvert(agentInvert), .agentWarMode(agentWarMode),
    .agentSeed(agentSeed), .agentStep(agentStep), .agentLoop(agentLoop),
    .agentSetupA(agentSetupA), .agentSetupB(agentSetupB),
    .busy(busy), .resValid(resValid), .resFault(resFault), .resErrWord(resErrWord)
  );

  // Agent model: completion after a latency of stable enables
  logic [7:0]  modelLat = 8'd4;
  logic [31:0] modelErr = '0;
  logic        modelNever = 1'b0;
  logic [1:0]  enPrev;
  logic [7:0]  modelCnt;
  logic        doneQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enPrev <= '0; modelCnt <= '0; doneQ <= 1'b0;
    end else begin
      enPrev <= {agentWrEn, agentRdEn};
      if ({agentWrEn, agentRdEn} != enPrev || {agentWrEn, agentRdEn} == 2'b00) begin
        modelCnt <= '0; doneQ <= 1'b0;
      end else if (!modelNever && modelCnt >= modelLat) begin
        doneQ <= 1'b1;
      end else begin
        modelCnt <= modelCnt + 1'b1;
      end
    end
  end
  assign cmpDone = doneQ;
  assign cmpErr  = doneQ ? modelErr : 32'hA5A5_5A5A;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: run hung actual=%0d expected<150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {mode[2], op, loop[5], lat[8], err[32], fault, inv, war}
  localparam int NV = 8;
  localparam logic [50:0] VEC [NV] = '{
    {2'b01, 1'b1, 5'd3,  8'd5, 32'h0000_0000, 1'b0, 1'b1, 1'b1},
    {2'b00, 1'b0, 5'd4,  8'd3, 32'h0000_0104, 1'b0, 1'b1, 1'b1},
    {2'b10, 1'b0, 5'd15, 8'd6, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    {2'b00, 1'b1, 5'd0,  8'd2, 32'hFFFF_0000, 1'b0, 1'b0, 1'b0},
    {2'b01, 1'b0, 5'd7,  8'd4, 32'h0000_0001, 1'b0, 1'b1, 1'b0},
    {2'b10, 1'b1, 5'd9,  8'd1, 32'h8000_0000, 1'b0, 1'b0, 1'b0},
    {2'b11, 1'b0, 5'd2,  8'd3, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    {2'b00, 1'b0, 5'd16, 8'd3, 32'h0000_0000, 1'b1, 1'b0, 1'b0}
  };

  // Launch one run and observe it until the result has come and gone
  task automatic runOne(input logic [50:0] v, input int idx);
    logic [1:0] m; logic op; logic [4:0] lp; logic exF, exInv, exWar;
    bit sawEn, sawRd, gapBad, firstWrAlone, prevWr, prevDone;
    int rdRise, doneRise, resAt, resCnt, i;
    logic [31:0] errAt, sA, sB;
    logic fltAt, rdAtRes;
    m = v[50:49]; op = v[48]; lp = v[47:43];
    exF = v[2]; exInv = v[1]; exWar = v[0];
    sA = 32'h1000_0000 + 32'(idx); sB = 32'h0000_0400 + 32'(idx * 16);
    @(negedge clk);
    modelLat = v[42:35]; modelErr = v[34:3];
    modeSel = m; opWrite = op; loopLog2 = lp; setupA = sA; setupB = sB; start = 1'b1;
    @(negedge clk);
    start = 1'b0; setupA = '1; setupB = '1; loopLog2 = 5'd1;
    sawEn = 0; sawRd = 0; gapBad = 0; firstWrAlone = 0; prevWr = 0; prevDone = 0;
    rdRise = -1; doneRise = -1; resAt = -1; resCnt = 0; errAt = '0; fltAt = 0; rdAtRes = 0;
    for (i = 0; i < 400; i++) begin
      if ((agentWrEn || agentRdEn) && !sawEn) firstWrAlone = agentWrEn && !agentRdEn;
      if (agentWrEn || agentRdEn) sawEn = 1;
      if (prevWr && !agentWrEn && agentRdEn) gapBad = 1;
      if (agentRdEn && !sawRd) begin
        sawRd = 1; rdRise = i;
        chk(agentAudio == m[0] && agentXtalk == m[1], "R3 selects", {30'd0, agentXtalk, agentAudio}, {30'd0, m});
        chk(agentInvert == exInv, "R4/R5/R6 inversion", {31'd0, agentInvert}, {31'd0, exInv});
        chk(agentWarMode == exWar, "R6/R7 write-after-read", {31'd0, agentWarMode}, {31'd0, exWar});
        chk(agentSeed == 8'h11 && agentStep == 8'h0D, "R4 seed/step", {16'd0, agentSeed, agentStep}, 32'h0000_110D);
        chk(agentLoop == lp[3:0] && agentSetupA == sA && agentSetupB == sB, "R13 captured config",
            agentSetupA, sA);
      end
      if (agentRdEn && cmpDone && !prevDone) doneRise = i;
      if (resValid) begin
        resCnt++;
        if (resAt < 0) begin resAt = i; errAt = resErrWord; fltAt = resFault; rdAtRes = agentRdEn; end
      end
      prevWr = agentWrEn; prevDone = cmpDone;
      if (resAt >= 0 && i > resAt + 2) break;
      @(negedge clk);
    end
    chk(resCnt == 1, "R10 single result pulse", resCnt, 1);
    chk(fltAt == exF, "R2/R3/R10 fault flag", {31'd0, fltAt}, {31'd0, exF});
    if (exF) begin
      chk(!sawEn, "R2/R3 no enable on rejected start", {31'd0, sawEn}, 0);
      chk(resAt == 0 && errAt == 0, "R2 result next cycle, word 0", resAt, 0);
    end else begin
      chk(errAt == v[34:3], "R9/R10 error word", errAt, v[34:3]);
      chk(resAt - doneRise == GUARD + 1, "R9 guard interval", resAt - doneRise, GUARD + 1);
      chk(!rdAtRes, "R9 read cleared with result", {31'd0, rdAtRes}, 0);
      if (op) chk(firstWrAlone && !gapBad, "R8 write first, idle gap before read",
                  {30'd0, firstWrAlone, gapBad}, 32'h2);
      else    chk(!firstWrAlone, "R7 read-only run", {31'd0, firstWrAlone}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!agentWrEn && !agentRdEn && !resValid && !busy && !resFault, "R1 reset outputs",
        {27'd0, agentWrEn, agentRdEn, resValid, busy, resFault}, 0);
    chk(!agentAudio && !agentXtalk && !agentInvert && !agentWarMode && agentSeed == 0 && agentStep == 0,
        "R1 reset pattern controls", {16'd0, agentSeed, agentStep}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !resValid, "R1 idle after reset", {30'd0, busy, resValid}, 0);

    for (int k = 0; k < NV; k++) runOne(VEC[k], k);

    // R11: compare-complete never arrives in the read phase
    begin
      int rdAt, resAtT, i;
      bit bothLow;
      modelNever = 1'b1;
      @(negedge clk);
      modeSel = 2'b00; opWrite = 1'b0; loopLog2 = 5'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0; rdAt = -1; resAtT = -1; bothLow = 0;
      for (i = 0; i < 300; i++) begin
        if (agentRdEn && rdAt < 0) rdAt = i;
        if (resValid) begin
          resAtT = i;
          bothLow = !agentWrEn && !agentRdEn;
          chk(resFault && resErrWord == 0, "R11 timeout fault, word 0", resErrWord, 0);
          break;
        end
        @(negedge clk);
      end
      chk(resAtT - rdAt == TMO, "R11 timeout distance", resAtT - rdAt, TMO);
      chk(bothLow, "R11 enables dropped", {31'd0, bothLow}, 1);
      modelNever = 1'b0;
    end

    // R12: a start during a run is ignored
    begin
      int resCnt, enAfter, i;
      bit wrSeen;
      @(negedge clk);
      modelLat = 8'd20; modelErr = 32'h0000_0077;
      modeSel = 2'b10; opWrite = 1'b0; loopLog2 = 5'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      modeSel = 2'b01; opWrite = 1'b1; loopLog2 = 5'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      resCnt = 0; enAfter = 0; wrSeen = 0;
      for (i = 0; i < 120; i++) begin
        if (agentWrEn) wrSeen = 1;
        if (resValid) begin
          resCnt++;
          chk(resErrWord == 32'h77 && !resFault, "R12 first run completes", resErrWord, 32'h77);
        end else if (resCnt > 0 && (agentWrEn || agentRdEn)) enAfter++;
        @(negedge clk);
      end
      chk(resCnt == 1 && enAfter == 0, "R12 no queued run", resCnt, 1);
      chk(!wrSeen && agentXtalk && !agentAudio && agentLoop == 4'd5, "R12 run unchanged",
          {28'd0, agentLoop}, 5);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule